// File: doc/BRIEF.md
# Receive Descriptor Completion Writer

This block collects completion records for received frames and writes them back to host memory in batches. Each time the receive path finishes storing a frame, it presents the frame's buffer address, length, checksum, VLAN tag, status flags, error flags and ring slot index on a valid/ready input. The block packs these into a 16-byte record and holds it in an on-chip pending queue.

The block compares the number of pending records against a programmable write-back threshold. When the count reaches the threshold, it streams exactly that many records, oldest first, as one burst on a valid/ready write port. The threshold counts either single descriptors or whole cache lines of descriptors, as a granularity bit selects. Once the last beat of a burst is accepted, a one-cycle done pulse reports how many records were written, so that the ring manager can advance its head pointer by that amount.

Back-pressure rules. On the completion input, a transfer happens in any cycle where `cpl_valid` and `cpl_ready` are both high. `cpl_ready` drops only while the pending queue is full, and it rises again once a burst beat drains an entry. On the write port, once `wr_valid` is high it stays high with `wr_data`, `wr_idx` and `wr_last` held steady until `wr_ready` accepts the beat. The write side may stall for any number of cycles.

Top module: `rxwb_engine`

## Requirements
- R1: A record is 128 bits, least significant first: bits 63:0 hold the buffer address exactly as presented, bits 79:64 the length, bits 95:80 the checksum, bits 103:96 the status byte, bits 111:104 the error byte and bits 127:112 the VLAN tag.
- R2: Status bit 0 (descriptor done, record bit 96) is 1 in every written record. Status bits 7:1 are copied from the input.
- R3: Error bits 3 and 4 (record bits 107 and 108) are always written as 0. The other error bits are copied from the input.
- R4: A burst begins only when the pending count is at least the effective threshold, and it carries exactly that many records. The effective threshold is `cfg_wthresh` when `cfg_gran` is 1, and `cfg_wthresh` times `LINE_DESC` when `cfg_gran` is 0.
- R5: A `cfg_wthresh` of 0 acts as 1, so with `cfg_gran`=1 every record is written as soon as it completes.
- R6: An effective threshold larger than `DEPTH` is reduced to `DEPTH`.
- R7: `cpl_ready` is low exactly when `DEPTH` records are pending.
- R8: Records leave in completion order, each with its ring index on `wr_idx`. `wr_last` marks the final beat of a burst, and a stalled beat holds its data.
- R9: `done_valid` pulses for one cycle, in the cycle after the final beat is accepted, with `done_count` equal to the burst length.
- R10: After reset, `wr_valid` and `done_valid` are low and `cpl_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wthresh | input | TH_W | Write-back threshold |
| cfg_gran | input | 1 | Threshold unit: 1 descriptors, 0 cache lines |
| cpl_valid | input | 1 | Completion record offered |
| cpl_ready | output | 1 | Completion accepted (queue not full) |
| cpl_addr | input | 64 | Buffer address of the descriptor |
| cpl_len | input | 16 | Frame length |
| cpl_csum | input | 16 | Frame checksum |
| cpl_vlan | input | 16 | VLAN tag |
| cpl_stat | input | 8 | Status flags |
| cpl_err | input | 8 | Error flags |
| cpl_idx | input | IDX_W | Ring slot index |
| wr_valid | output | 1 | Burst beat valid |
| wr_ready | input | 1 | Burst beat accepted |
| wr_data | output | 128 | Packed record |
| wr_idx | output | IDX_W | Ring slot of the record |
| wr_last | output | 1 | Final beat of the burst |
| done_valid | output | 1 | Burst completed pulse |
| done_count | output | CW | Records written in the burst |

## Verification
The bench builds the block with its defaults: DEPTH 8, LINE_DESC 4 and a 6-bit threshold. With these values, line granularity with a threshold of 1 gives bursts of four, and a threshold of 3 asks for twelve, which exercises the clamp to eight. A queue of eight fills in a few frames, so holding `wr_ready` low quickly reaches the full and back-pressured state. Random thresholds from 0 to 9 in both units cover the zero case, plain descriptor counts and the clamp, while random write stalls exercise beat holding.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  typedef struct packed {
    logic [15:0] vlan;
    logic [7:0]  err;
    logic [7:0]  stat;
    logic [15:0] csum;
    logic [15:0] len;
    logic [63:0] addr;
  } rxwb_rec_t;

  localparam logic [7:0] STAT_FORCE_SET = 8'h01;
  localparam logic [7:0] ERR_KEEP_MASK  = 8'hE7;
endpackage

// File: rtl/rxwb_pack.sv
module rxwb_pack
  import rxwb_pkg::*;
(
  input  logic [63:0] addr,
  input  logic [15:0] len,
  input  logic [15:0] csum,
  input  logic [15:0] vlan,
  input  logic [7:0]  stat,
  input  logic [7:0]  err,
  output rxwb_rec_t   rec
);
  always_comb begin
    rec.addr = addr;
    rec.len  = len;
    rec.csum = csum;
    rec.vlan = vlan;
    rec.stat = stat | STAT_FORCE_SET;
    rec.err  = err & ERR_KEEP_MASK;
  end
endmodule

// File: rtl/rxwb_fifo.sv
module rxwb_fifo #(
  parameter int W     = 132,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full = (count == CW'(DEPTH));
  assign dout = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop)
        rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxwb_ctrl.sv
module rxwb_ctrl #(
  parameter int DEPTH     = 8,
  parameter int LINE_DESC = 4,
  parameter int TH_W      = 6,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int LW  = (LINE_DESC > 1) ? $clog2(LINE_DESC) + 1 : 1,
  localparam int EW  = TH_W + LW,
  localparam int XW  = (EW > CW) ? EW : CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TH_W-1:0] cfg_wthresh,
  input  logic            cfg_gran,
  input  logic [CW-1:0]   pend,
  input  logic            wr_ready,
  output logic            wr_valid,
  output logic            wr_last,
  output logic            done_valid,
  output logic [CW-1:0]   done_count
);
  typedef enum logic {S_IDLE, S_BURST} st_t;
  st_t st;
  logic [XW-1:0] th1, eff_raw, eff;
  logic [CW-1:0] blen, beat;

  always_comb begin
    th1     = (cfg_wthresh == '0) ? XW'(1) : XW'(cfg_wthresh);
    eff_raw = cfg_gran ? th1 : th1 * XW'(LINE_DESC);
    eff     = (eff_raw > XW'(DEPTH)) ? XW'(DEPTH) : eff_raw;
  end

  assign wr_valid = (st == S_BURST);
  assign wr_last  = wr_valid && (beat == blen - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      blen       <= '0;
      beat       <= '0;
      done_valid <= 1'b0;
      done_count <= '0;
    end else begin
      done_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (XW'(pend) >= eff) begin
            st   <= S_BURST;
            blen <= CW'(eff);
            beat <= '0;
          end
        S_BURST:
          if (wr_ready) begin
            beat <= beat + 1'b1;
            if (wr_last) begin
              st         <= S_IDLE;
              done_valid <= 1'b1;
              done_count <= blen;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine
  import rxwb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int LINE_DESC = 4,
  parameter int TH_W      = 6,
  parameter int IDX_W     = 4,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int RW       = $bits(rxwb_rec_t),
  localparam int QW       = RW + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TH_W-1:0]  cfg_wthresh,
  input  logic             cfg_gran,
  input  logic             cpl_valid,
  output logic             cpl_ready,
  input  logic [63:0]      cpl_addr,
  input  logic [15:0]      cpl_len,
  input  logic [15:0]      cpl_csum,
  input  logic [15:0]      cpl_vlan,
  input  logic [7:0]       cpl_stat,
  input  logic [7:0]       cpl_err,
  input  logic [IDX_W-1:0] cpl_idx,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [RW-1:0]    wr_data,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_last,
  output logic             done_valid,
  output logic [CW-1:0]    done_count
);
  rxwb_rec_t     rec;
  logic [QW-1:0] q_out;
  logic [CW-1:0] pend_cnt;
  logic          q_full;

  rxwb_pack u_pack (
    .addr(cpl_addr), .len(cpl_len), .csum(cpl_csum),
    .vlan(cpl_vlan), .stat(cpl_stat), .err(cpl_err), .rec(rec)
  );

  rxwb_fifo #(.W(QW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(cpl_valid && cpl_ready), .din({cpl_idx, rec}),
    .pop(wr_valid && wr_ready), .dout(q_out),
    .count(pend_cnt), .full(q_full)
  );

  rxwb_ctrl #(.DEPTH(DEPTH), .LINE_DESC(LINE_DESC), .TH_W(TH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_wthresh(cfg_wthresh), .cfg_gran(cfg_gran),
    .pend(pend_cnt), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_last(wr_last),
    .done_valid(done_valid), .done_count(done_count)
  );

  assign cpl_ready = !q_full;
  assign wr_data   = q_out[RW-1:0];
  assign wr_idx    = q_out[QW-1:RW];
endmodule

// File: rtl/rxwb_chk.sv
module rxwb_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpl_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [127:0]     wr_data,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_last,
  input logic             done_valid,
  input logic [CW-1:0]    done_count,
  input logic [CW-1:0]    pend_cnt
);
  AST_DD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[96]); // R2
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[108:107] == 2'b00)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == CW'(DEPTH)) |-> !cpl_ready); // R7
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_idx) && $stable(wr_last))); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_last) |=> (done_valid && !wr_valid)); // R9
  AST_DONE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_count != '0)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R9
endmodule

bind rxwb_engine rxwb_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpl_ready(cpl_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
  .wr_idx(wr_idx), .wr_last(wr_last), .done_valid(done_valid),
  .done_count(done_count), .pend_cnt(pend_cnt)
);

// File: tb/sim_rxwb_engine.sv
`timescale 1ns/1ps
module sim_rxwb_engine;
  localparam int PERIOD    = 10;
  localparam int DEPTH     = 8;
  localparam int LINE_DESC = 4;
  localparam int TH_W      = 6;
  localparam int IDX_W     = 4;
  localparam int CW        = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TH_W-1:0] cfg_wthresh = '0;
  logic cfg_gran = 1'b1;
  logic cpl_valid = 1'b0, cpl_ready;
  logic [63:0] cpl_addr = '0;
  logic [15:0] cpl_len = '0, cpl_csum = '0, cpl_vlan = '0;
  logic [7:0] cpl_stat = '0, cpl_err = '0;
  logic [IDX_W-1:0] cpl_idx = '0;
  logic wr_valid, wr_ready = 1'b1, wr_last, done_valid;
  logic [127:0] wr_data;
  logic [IDX_W-1:0] wr_idx;
  logic [CW-1:0] done_count;

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  rxwb_engine #(.DEPTH(DEPTH), .LINE_DESC(LINE_DESC), .TH_W(TH_W), .IDX_W(IDX_W)) u0 (.*);

  task automatic check(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_of(input logic [TH_W-1:0] w, input logic g);
    int t;
    t = (w == 0) ? 1 : int'(w);
    if (!g) t = t * LINE_DESC;
    return (t > DEPTH) ? DEPTH : t;
  endfunction

  function automatic logic [131:0] exp_rec(input logic [IDX_W-1:0] idx, input logic [15:0] vl,
      input logic [7:0] er, input logic [7:0] st, input logic [15:0] cs,
      input logic [15:0] ln, input logic [63:0] ad);
    return {idx, vl, er & 8'hE7, st | 8'h01, cs, ln, ad};
  endfunction

  // write-side ready generator
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: wr_ready <= 1'b1;
      1: wr_ready <= 1'($urandom % 2);
      default: wr_ready <= 1'b0;
    endcase
  end

  // monitor and scoreboard
  logic [131:0] mq[$];
  int  beats = 0, burst_eff = 0, eff_prev = 1;
  bit  in_burst = 0, exp_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(done_valid == exp_done, "R9 done timing", 136'(done_valid), 136'(exp_done));
      exp_done = 0;
      if (done_valid) begin
        check(int'(done_count) == burst_eff, "R9 done_count", 136'(done_count), 136'(burst_eff));
        beats = 0;
      end
      check(cpl_ready == (mq.size() != DEPTH), "R7 ready vs fill", 136'(cpl_ready), 136'(mq.size() != DEPTH));
      if (wr_valid && !in_burst) begin
        in_burst = 1;
        burst_eff = eff_prev;
        check(mq.size() >= burst_eff, "R4 burst start level", 136'(mq.size()), 136'(burst_eff));
      end
      if (wr_valid && wr_ready) begin
        logic [131:0] e;
        e = mq.pop_front();
        beats++;
        check({wr_idx, wr_data} == e, "R1 record contents", 136'({wr_idx, wr_data}), 136'(e));
        check(wr_last == (beats == burst_eff), "R8 last flag", 136'(wr_last), 136'(beats == burst_eff));
        if (wr_last) begin in_burst = 0; exp_done = 1; end
      end
      if (cpl_valid && cpl_ready)
        mq.push_back(exp_rec(cpl_idx, cpl_vlan, cpl_err, cpl_stat, cpl_csum, cpl_len, cpl_addr));
      eff_prev = eff_of(cfg_wthresh, cfg_gran);
    end
  end

  task automatic send();
    @(posedge clk); #1;
    cpl_addr  = {$urandom, $urandom};
    cpl_len   = 16'($urandom);
    cpl_csum  = 16'($urandom);
    cpl_vlan  = 16'($urandom);
    cpl_stat  = 8'($urandom);
    cpl_err   = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
    cpl_idx   = cpl_idx + 1'b1;
    cpl_valid = 1'b1;
    do @(negedge clk); while (!cpl_ready);
    @(posedge clk); #1;
    cpl_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [TH_W-1:0] w, input logic g);
    do @(negedge clk); while (wr_valid);
    @(posedge clk); #1;
    cfg_wthresh = w; cfg_gran = g;
  endtask

  task automatic drain();
    set_cfg('0, 1'b1);
    rdy_mode = 0;
    while (mq.size() != 0 || in_burst) @(negedge clk);
    repeat (3) @(negedge clk);
    check(mq.size() == 0 && !wr_valid, "R5 drained with zero threshold", 136'(mq.size()), 136'(0));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!wr_valid && !done_valid && cpl_ready, "R10 reset state",
          136'({wr_valid, done_valid, cpl_ready}), 136'(3'b001));

    // R4: descriptor units, threshold 3
    set_cfg(6'd3, 1'b1);
    for (int i = 0; i < 2; i++) send();
    repeat (6) @(negedge clk);
    check(!wr_valid && mq.size() == 2, "R4 below threshold holds", 136'(wr_valid), 136'(0));
    for (int i = 0; i < 7; i++) send();
    drain();

    // R5: zero threshold, one record per burst
    set_cfg(6'd0, 1'b1);
    for (int i = 0; i < 4; i++) send();
    drain();

    // R4: cache-line units, 1 line = LINE_DESC records, random stalls
    set_cfg(6'd1, 1'b0);
    rdy_mode = 1;
    for (int i = 0; i < 8; i++) send();
    drain();

    // R6 + R7: clamp to DEPTH, write port stalled until queue full
    set_cfg(6'd3, 1'b0);
    rdy_mode = 2;
    for (int i = 0; i < DEPTH; i++) send();
    repeat (5) @(negedge clk);
    check(!cpl_ready, "R7 back-pressure when full", 136'(cpl_ready), 136'(0));
    check(wr_valid, "R6 clamped burst pending", 136'(wr_valid), 136'(1));
    rdy_mode = 1;
    drain();

    // random segments
    for (int s = 0; s < 30; s++) begin
      logic [TH_W-1:0] w;
      logic g;
      int e;
      w = TH_W'($urandom % 10);
      g = 1'($urandom % 2);
      e = eff_of(w, g);
      set_cfg(w, g);
      rdy_mode = ($urandom % 3 == 0) ? 0 : 1;
      for (int i = 0; i < e * (1 + $urandom % 3); i++) send();
      drain();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule